// File: doc/BRIEF.md
# External Interrupt Pin Request Controller

This block takes a row of asynchronous interrupt pins, brings each one into the clock domain and turns activity on it into a per-channel request flag. For each channel, software selects the active sense, edge or level detection, and whether both transitions count. It also sets a three-bit priority. Each flag gates a request line toward an interrupt arbiter, and the channel's priority is passed along beside it. Choosing a vector, arbitrating between channels and the processor core are handled elsewhere.

The lower `NFULL` channels are fully configurable. The remaining channels detect only a falling edge and keep just the priority and the flag. Software reaches the controls through a simple write port and a read port with one cycle of latency. A write to the polarity can raise a request on its own, because the pin is seen with a different sense from that cycle on. Software clears this request afterwards.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset, every flag, priority, polarity, mode bit and both-edge bit is 0, `irq_req` and `irq_lvl` are 0, and every address reads 0.
- R2: Each pin passes through two synchronizer flops. In one-edge mode with polarity 0, a falling pin that is stable before clock edge E0 sets the flag at E2 and raises `irq_req` at E3, provided the priority is nonzero.
- R3: In one-edge mode, polarity 1 reacts only to a rising edge and polarity 0 only to a falling edge. The opposite edge leaves the flag unchanged.
- R4: In edge mode with the channel's both-edge bit set, both rising and falling edges set the flag.
- R5: In level mode (control bit 5 = 1), the flag is set on every clock in which the active level (high for polarity 1, low for polarity 0) is sampled. A clearing write while that level is present leaves the flag at 1. The flag stays set after the level goes away, until it is cleared. The both-edge bit has no effect in this mode.
- R6: Writing a control byte with bit 0 = 0 clears the flag, and bit 0 = 1 leaves it unchanged. If a qualifying event lands in the same cycle as a clear, the event wins.
- R7: A write that changes the polarity so that the present pin state becomes active sets the flag in the following cycle, even when the pin does not move.
- R8: `irq_req[i]` is registered and equals the flag AND (priority ≠ 0) from the previous cycle. `irq_lvl[3i+2:3i]` carries the priority with the same one-cycle delay.
- R9: Addresses 0..NCH-1 hold the channel controls with flag in bit 0, priority in bits 3:1, polarity in bit 4 and level mode in bit 5. Address NCH holds the both-edge bits, one per full channel. Other addresses read 0. `rd_data` shows the value addressed in the previous cycle.
- R10: Channels NFULL and above ignore the polarity, mode and both-edge bits, read them as 0, and detect falling edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | NCH | Asynchronous interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| irq_req | output | NCH | Masked request per channel |
| irq_lvl | output | NCH*3 | Priority per channel, 3 bits each |

## Verification
A pin change driven before edge E0 reaches the flag at E2 and `irq_req` at E3. A register write at edge W shows up in the flag and controls at W. It reaches `irq_req` and `irq_lvl` at W+1, and a polarity-induced request sets the flag at W+1. A read address applied before edge R is returned at R. The bench drives all inputs on falling clock edges and advances an independent cycle model on each rising edge. On every falling edge it compares the outputs against that model, so every latency is checked exactly. Directed sequences wait the stated number of edges before sampling, including one that lines up a clear with an edge event in the same cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int LVL_W  = 3;
  localparam int B_FLAG = 0;
  localparam int B_LVL  = 1;
  localparam int B_POL  = B_LVL + LVL_W;
  localparam int B_LVM  = B_POL + 1;
  localparam int CTRL_W = B_LVM + 1;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   W    = 8,
  parameter int   N    = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) st[k] <= {W{IDLE}};
    end else begin
      st[0] <= d;
      for (int k = 1; k < N; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_s,
  input  logic              be_en,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_bits,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              req_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic             flag_q, prev_q, pol_q, lvm_q;
  logic [LVL_W-1:0] lvl_q;
  logic             act, hit, clr;

  generate
    if (FULL) begin : g_full
      always_ff @(posedge clk) begin
        if (rst) begin
          pol_q <= 1'b0;
          lvm_q <= 1'b0;
        end else if (wr_ctrl) begin
          pol_q <= wr_bits[B_POL];
          lvm_q <= wr_bits[B_LVM];
        end
      end
    end else begin : g_fixed
      logic fix_unused;
      assign fix_unused = wr_bits[B_POL] ^ wr_bits[B_LVM];
      assign pol_q = 1'b0;
      assign lvm_q = 1'b0;
    end
  endgenerate

  assign act = pol_q ? pin_s : ~pin_s;
  assign clr = wr_ctrl & ~wr_bits[B_FLAG];

  always_comb begin
    if (lvm_q)      hit = act;
    else if (be_en) hit = act ^ prev_q;
    else            hit = act & ~prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      prev_q <= 1'b0;
      lvl_q  <= '0;
      req_o  <= 1'b0;
      lvl_o  <= '0;
    end else begin
      flag_q <= hit | (flag_q & ~clr);
      prev_q <= act;
      if (wr_ctrl) lvl_q <= wr_bits[B_LVL +: LVL_W];
      req_o  <= flag_q & (|lvl_q);
      lvl_o  <= lvl_q;
    end
  end

  always_comb begin
    ctrl_o                    = '0;
    ctrl_o[B_FLAG]            = flag_q;
    ctrl_o[B_LVL +: LVL_W]    = lvl_q;
    ctrl_o[B_POL]             = pol_q;
    ctrl_o[B_LVM]             = lvm_q;
  end

  // R6: a set flag survives every cycle without a clearing write
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R6: no event means the flag cannot rise, whatever is written
  a_r6_no_self_set: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !hit) |=> !flag_q);
  // R5: an active level in level mode always leaves the flag set
  a_r5_level_sets: assert property (@(posedge clk) disable iff (rst)
    (lvm_q && act) |=> flag_q);
  // R8: the request line only follows a flag that was set
  a_r8_req_from_flag: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(flag_q));
endmodule

// File: rtl/extint_rdmux.sv
module extint_rdmux
  import extint_pkg::*;
#(
  parameter int NCH   = 9,
  parameter int NFULL = 6,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         rd_addr,
  input  logic [NCH*CTRL_W-1:0] ctrl_flat,
  input  logic [NFULL-1:0]      be_q,
  output logic [CTRL_W-1:0]     rd_bits
);
  logic [CTRL_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(i)) sel = ctrl_flat[i*CTRL_W +: CTRL_W];
    if (rd_addr == AW'(NCH)) sel = CTRL_W'(be_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_bits <= '0;
    else     rd_bits <= sel;
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NCH    = 9,
  parameter int NFULL  = 6,
  parameter int DW     = 8,
  parameter int SYNC_N = 2,
  parameter int AW     = $clog2(NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       pins,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NCH-1:0]       irq_req,
  output logic [NCH*LVL_W-1:0] irq_lvl
);
  logic [NCH-1:0]        pin_s;
  logic [NFULL-1:0]      be_q;
  logic [NCH*CTRL_W-1:0] ctrl_flat;
  logic [CTRL_W-1:0]     rd_bits;
  logic                  top_unused;

  assign top_unused = ^wr_data[DW-1:CTRL_W];

  extint_sync #(.W(NCH), .N(SYNC_N), .IDLE(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d(pins), .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) be_q <= '0;
    else if (wr_en && wr_addr == AW'(NCH)) be_q <= wr_data[NFULL-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic be_bit;
    if (i < NFULL) begin : g_be
      assign be_bit = be_q[i];
    end else begin : g_nobe
      assign be_bit = 1'b0;
    end

    extint_chan #(.FULL(i < NFULL)) i_chan (
      .clk    (clk),
      .rst    (rst),
      .pin_s  (pin_s[i]),
      .be_en  (be_bit),
      .wr_ctrl(wr_en && wr_addr == AW'(i)),
      .wr_bits(wr_data[CTRL_W-1:0]),
      .ctrl_o (ctrl_flat[i*CTRL_W +: CTRL_W]),
      .req_o  (irq_req[i]),
      .lvl_o  (irq_lvl[i*LVL_W +: LVL_W])
    );

    // R8: a request never leaves with a zero priority beside it
    a_r8_req_needs_lvl: assert property (@(posedge clk) disable iff (rst)
      irq_req[i] |-> (irq_lvl[i*LVL_W +: LVL_W] != '0));
  end

  extint_rdmux #(.NCH(NCH), .NFULL(NFULL), .AW(AW)) i_rdmux (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .ctrl_flat(ctrl_flat),
    .be_q(be_q), .rd_bits(rd_bits)
  );

  assign rd_data = {{(DW-CTRL_W){1'b0}}, rd_bits};
endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH   = 9;
  localparam int NFULL = 6;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   pins = '1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic [7:0]       rd_data;
  logic [NCH-1:0]   irq_req;
  logic [NCH*3-1:0] irq_lvl;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  extint_ctrl i_extint_ctrl (
    .clk(clk), .rst(rst), .pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req), .irq_lvl(irq_lvl)
  );

  // independent cycle model built from the requirements
  logic [NCH-1:0]   m_s1, m_s2, m_prev, m_flag, m_pol, m_lv, m_req, m_be;
  logic [2:0]       m_lvl [NCH];
  logic [NCH*3-1:0] m_lvo;
  logic [7:0]       m_rd;
  logic [NCH-1:0]   n_flag, n_prev;

  function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
    if (a < AW'(NCH)) return {2'b00, m_lv[a], m_pol[a], m_lvl[a], m_flag[a]};
    if (a == AW'(NCH)) return 8'(m_be);
    return 8'h00;
  endfunction

  function automatic logic ev_of(input int c);
    logic a;
    a = m_pol[c] ? m_s2[c] : ~m_s2[c];
    if (m_lv[c]) return a;
    if (m_be[c]) return a ^ m_prev[c];
    return a & ~m_prev[c];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_prev = '0; m_flag = '0; m_pol = '0; m_lv = '0;
      m_req = '0; m_be = '0; m_lvo = '0; m_rd = '0;
      for (int c = 0; c < NCH; c++) m_lvl[c] = '0;
    end else begin
      m_rd = exp_read(rd_addr);
      for (int c = 0; c < NCH; c++) begin
        n_flag[c] = ev_of(c) |
          (m_flag[c] & ~(wr_en && wr_addr == AW'(c) && !wr_data[0]));
        n_prev[c] = m_pol[c] ? m_s2[c] : ~m_s2[c];
        m_req[c]  = m_flag[c] && (m_lvl[c] != 3'd0);
        m_lvo[c*3 +: 3] = m_lvl[c];
      end
      if (wr_en) begin
        for (int c = 0; c < NCH; c++) begin
          if (wr_addr == AW'(c)) begin
            m_lvl[c] = wr_data[3:1];
            if (c < NFULL) begin
              m_pol[c] = wr_data[4];
              m_lv[c]  = wr_data[5];
            end
          end
        end
        if (wr_addr == AW'(NCH)) m_be = NCH'(wr_data[NFULL-1:0]);
      end
      m_flag = n_flag;
      m_prev = n_prev;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R8 and R9 checked every cycle against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 irq_req vs model", 32'(irq_req), 32'(m_req));
      chk("R8 irq_lvl vs model", 32'(irq_lvl), 32'(m_lvo));
      chk("R9 rd_data vs model", 32'(rd_data), 32'(m_rd));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4321));
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 irq_req after reset", 32'(irq_req), 0);
    chk("R1 irq_lvl after reset", 32'(irq_lvl), 0);
    rd(0, v);  chk("R1 ctrl0 after reset", 32'(v), 0);
    rd(AW'(NCH), v); chk("R1 both-edge reg after reset", 32'(v), 0);

    // R2 latency on a falling edge, polarity 0, priority 3
    wr(0, 8'h06);
    step(2);
    pins[0] = 1'b0;
    step(3);
    chk("R2 no request before E3", 32'(irq_req[0]), 0);
    step(1);
    chk("R2 request at E3", 32'(irq_req[0]), 1);
    chk("R8 priority forwarded", 32'(irq_lvl[2:0]), 3);

    // R6 clear and ignored set
    wr(0, 8'h06);
    step(1);
    chk("R6 request dropped after clear", 32'(irq_req[0]), 0);
    wr(0, 8'h07);
    rd(0, v); chk("R6 write of 1 ignored", 32'(v), 32'h06);

    // R3 rising edge ignored at polarity 0
    pins[0] = 1'b1;
    step(5);
    rd(0, v); chk("R3 rising ignored pol0", 32'(v), 32'h06);

    // R7 polarity switch raises a request with a still pin
    wr(0, 8'h16);
    rd(0, v); chk("R7 spurious request on polarity change", 32'(v), 32'h17);
    wr(0, 8'h16);
    step(4);
    rd(0, v); chk("R7 cleared stays clear", 32'(v), 32'h16);

    // R3 polarity 1: falling ignored, rising detected
    pins[0] = 1'b0;
    step(5);
    rd(0, v); chk("R3 falling ignored pol1", 32'(v), 32'h16);
    pins[0] = 1'b1;
    step(5);
    rd(0, v); chk("R3 rising detected pol1", 32'(v), 32'h17);

    // R8 zero priority masks a set flag
    wr(0, 8'h11);
    step(2);
    chk("R8 zero priority masks request", 32'(irq_req[0]), 0);
    rd(0, v); chk("R8 flag still set under mask", 32'(v), 32'h11);

    // R4 both-edge on channel 1
    wr(AW'(NCH), 8'h02);
    wr(1, 8'h04);
    step(4);
    pins[1] = 1'b0;
    step(5);
    rd(1, v); chk("R4 falling edge in both-edge", 32'(v), 32'h05);
    wr(1, 8'h04);
    step(2);
    rd(1, v); chk("R4 cleared", 32'(v), 32'h04);
    pins[1] = 1'b1;
    step(5);
    rd(1, v); chk("R4 rising edge in both-edge", 32'(v), 32'h05);

    // R5 level mode, active low, both-edge bit set but ignored
    wr(AW'(NCH), 8'h06);
    wr(2, 8'h22);
    pins[2] = 1'b0;
    step(5);
    rd(2, v); chk("R5 level sets flag", 32'(v), 32'h23);
    chk("R5 request while level held", 32'(irq_req[2]), 1);
    wr(2, 8'h22);
    rd(2, v); chk("R5 clear while active has no effect", 32'(v), 32'h23);
    pins[2] = 1'b1;
    step(5);
    rd(2, v); chk("R5 flag held after level ends", 32'(v), 32'h23);
    wr(2, 8'h22);
    step(2);
    rd(2, v); chk("R5 clear when inactive", 32'(v), 32'h22);

    // R6 event wins over a clear in the same cycle (channel 3)
    wr(3, 8'h02);
    step(3);
    pins[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3; wr_data = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3, v); chk("R6 edge beats simultaneous clear", 32'(v), 32'h03);

    // R10 fixed channel 7
    wr(7, 8'h36);
    rd(7, v); chk("R10 fixed channel keeps only priority", 32'(v), 32'h06);
    pins[7] = 1'b0;
    step(5);
    rd(7, v); chk("R10 fixed channel falling edge", 32'(v), 32'h07);
    wr(AW'(NCH), 8'hFF);
    rd(AW'(NCH), v); chk("R10 both-edge bits only for full channels", 32'(v), 32'h3F);

    // R9 unmapped address
    rd(4'd12, v); chk("R9 unmapped reads zero", 32'(v), 0);

    // random phase, checked every cycle by the model
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if ($urandom_range(0, 7) == 0) begin
        int p;
        p = $urandom_range(0, NCH-1);
        pins[p] = ~pins[p];
      end
      if ($urandom_range(0, 5) == 0) begin
        wr_en   = 1'b1;
        wr_addr = AW'($urandom_range(0, 10));
        wr_data = 8'($urandom);
      end
      rd_addr = AW'($urandom_range(0, 15));
    end
    @(negedge clk);
    wr_en = 1'b0;
    step(4);
    finish_run();
  end
endmodule